// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that advances on one of two count sources: an internal tick that fires once every four system clocks, or rising edges seen on an external clock pin. The chosen source goes through a prescaler that divides by 1, 2, 4 or 8 before it reaches the counter. External edges can be taken either through a two-flop synchronizer or through a single sampling flop. The single flop gives one clock less latency.

The count is built from 8-bit lanes with a ripple carry between them. The current value of the count can be overwritten in a single cycle. A pulse from a compare unit clears the count to zero. When the count wraps from its maximum value to zero, a sticky overflow flag is set, and it stays set until a clear input is asserted. An integrator drives the control levels directly and reads the count and flag as plain outputs.

Top module: `pst_timer16`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `count` is 0 and `ovf_flag` is 0. The prescaler and the internal tick phase also restart from zero.
- R2: With `src_ext`=0, `run_en`=1 and `pre_code`=0, `count` increases by exactly one every four system clocks. The internal tick phase runs freely from reset.
- R3: With `src_ext`=1, each 0-to-1 transition of `ext_clk` counts as one source event, provided each level is held for at least one system clock. Falling transitions are not counted.
- R4: `pre_code` values 0, 1, 2 and 3 divide the source events by 1, 2, 4 and 8 respectively.
- R5: With `sync_on`=0, a rising edge that is sampled at clock edge k counts at clock edge k+1. With `sync_on`=1, the same edge counts at clock edge k+2.
- R6: With `run_en`=0, `count` holds its value and the prescaler does not advance. Edges on `ext_clk` and internal ticks have no effect.
- R7: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag` on the same clock edge.
- R8: `ovf_flag` stays at 1 until `ovf_clr` is asserted. If a rollover and `ovf_clr` happen in the same cycle, the flag stays at 1.
- R9: `evt_clr` sets `count` to 0 on the next edge. It takes priority over a load and over an increment in the same cycle, and a rollover that it blocks does not set the flag.
- R10: `ld_we` replaces the full 16-bit count with `ld_val` and takes priority over an increment in the same cycle. It also restarts the prescaler.
- R11: The prescaler restarts at zero in any cycle where `pre_code` or `src_ext` differs from its value in the previous cycle. No increment is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | Source select: 0 = internal tick every 4 clocks, 1 = external edges |
| pre_code | input | 2 | Prescale code: 0 = /1, 1 = /2, 2 = /4, 3 = /8 |
| sync_on | input | 1 | 1 = two-flop synchronizer on the external input, 0 = single-flop sampling |
| ext_clk | input | 1 | External count pin |
| evt_clr | input | 1 | Trigger pulse that clears the count |
| ld_we | input | 1 | Write strobe that loads the count |
| ld_val | input | 16 | Value to load |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Several functions of this block can land on the same clock edge. Two of them matter most: a load or trigger clear arriving together with a prescaled increment, and a rollover arriving while the flag clear is held high. The bench keeps `ovf_clr` high across the cycle where a preloaded 0xFFFF wraps. It also issues a load and a trigger clear together while the counter is running from its fastest source. A behavioural model decides the outcome of each collision from the priority rules, and every clock both outputs are compared against it.

// File: rtl/pst_tmr_pkg.sv
// Package: shared types and helpers of the prescaled timer.
// Assumes: the prescale code is 2 bits wide; the divisors are powers of two.
package pst_tmr_pkg;

    typedef enum logic [1:0] {
        PS_DIV1 = 2'd0,
        PS_DIV2 = 2'd1,
        PS_DIV4 = 2'd2,
        PS_DIV8 = 2'd3
    } ps_code_t;

    localparam int PS_CNT_W = 3;

    // Terminal value of the prescaler counter for a given code (divisor - 1).
    function automatic logic [PS_CNT_W-1:0] ps_last(input ps_code_t code);
        case (code)
            PS_DIV1: ps_last = 3'd0;
            PS_DIV2: ps_last = 3'd1;
            PS_DIV4: ps_last = 3'd3;
            default: ps_last = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/pst_tick_source.sv
// Module: pst_tick_source
// Picks the raw count source. Internal: a free-running phase counter that
// produces one tick every INT_DIV clocks. External: the pin is sampled by a
// shift register, and a rising edge is detected either after one flop
// (sync_on=0) or after two synchronizing flops (sync_on=1).
// Assumes: ext_pin holds each level for at least one clock; INT_DIV >= 2.
module pst_tick_source #(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext,
    input  logic sync_on,
    input  logic ext_pin,
    output logic src_tick
);
    localparam int PH_W = $clog2(INT_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INT_DIV - 1);
    localparam int HIST_N = 3;

    logic [PH_W-1:0]   phase_q;
    logic [HIST_N-1:0] hist_q;
    logic              int_tick;
    logic              edge_fast;
    logic              edge_sync;
    logic              ext_tick;

    // Free-running instruction-rate phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                         phase_q <= phase_q + 1'b1;
    end

    // Sampling shift register on the external pin.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_N-2:0], ext_pin};
    end

    // Edge detection for both latencies and the final source select.
    always_comb begin
        int_tick  = (phase_q == PH_LAST);
        edge_fast = hist_q[0] & ~hist_q[1];
        edge_sync = hist_q[1] & ~hist_q[2];
        ext_tick  = sync_on ? edge_sync : edge_fast;
        src_tick  = src_ext ? ext_tick : int_tick;
    end

endmodule

// File: rtl/pst_prescaler.sv
// Module: pst_prescaler
// Divides the source ticks by 1/2/4/8 while run_en is set. The divider
// counter restarts when the code or source changes, or when the count is
// loaded, and no increment comes out in a restart cycle.
// Assumes: the restart conditions are level inputs sampled every clock.
module pst_prescaler
    import pst_tmr_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              src_tick,
    input  logic [CODE_W-1:0] code,
    input  logic              src_ext,
    input  logic              ld_we,
    output logic              inc
);
    logic [PS_CNT_W-1:0] pcnt_q;
    logic [CODE_W-1:0]   code_q;
    logic                src_q;
    logic                restart;
    logic                step;
    logic                at_last;

    // Remember the previous code and source so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            src_q  <= 1'b0;
        end else begin
            code_q <= code;
            src_q  <= src_ext;
        end
    end

    // Restart, step and terminal-count decode.
    always_comb begin
        restart = (code != code_q) | (src_ext != src_q) | ld_we;
        step    = run_en & src_tick & ~restart;
        at_last = (pcnt_q == ps_last(ps_code_t'(code)));
        inc     = step & at_last;
    end

    // Divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt_q <= '0;
        else if (restart) pcnt_q <= '0;
        else if (step)    pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
    end

endmodule

// File: rtl/pst_count_core.sv
// Module: pst_count_core
// The count register, built from 8-bit lanes with a ripple carry between
// them, plus the sticky overflow flag. Priority is clear, then load, then
// increment. For the flag, a set takes priority over a clear.
// Assumes: CNT_W is a multiple of 8.
module pst_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_clr,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    localparam int LANE_W = 8;
    localparam int NLANE  = CNT_W / LANE_W;

    logic [NLANE:0] carry;
    logic           wrap;
    logic           ovf_q;

    assign carry[0] = inc & ~evt_clr & ~ld_we;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // One lane: clear, load its slice, or add its incoming carry.
        always_ff @(posedge clk) begin
            if (!rst_n)        lane_q <= '0;
            else if (evt_clr)  lane_q <= '0;
            else if (ld_we)    lane_q <= ld_val[i*LANE_W +: LANE_W];
            else if (carry[i]) lane_q <= lane_q + 1'b1;
        end

        assign carry[i+1]                   = carry[i] & (&lane_q);
        assign count[i*LANE_W +: LANE_W]    = lane_q;
    end

    assign wrap = carry[NLANE];

    // Sticky overflow flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign ovf_flag = ovf_q;

endmodule

// File: rtl/pst_timer16.sv
// Module: pst_timer16 (top)
// Prescaled timer/counter: picks a source, divides it, and counts it into
// a lane-built register with a sticky overflow flag.
// Assumes: all control inputs are synchronous to clk; ext_clk is treated
// as asynchronous and is only sampled.
module pst_timer16 #(
    parameter int CNT_W   = 16,
    parameter int INT_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             src_ext,
    input  logic [1:0]       pre_code,
    input  logic             sync_on,
    input  logic             ext_clk,
    input  logic             evt_clr,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    logic src_tick;
    logic inc;

    pst_tick_source #(.INT_DIV(INT_DIV)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_ext  (src_ext),
        .sync_on  (sync_on),
        .ext_pin  (ext_clk),
        .src_tick (src_tick)
    );

    pst_prescaler #(.CODE_W(2)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .src_tick (src_tick),
        .code     (pre_code),
        .src_ext  (src_ext),
        .ld_we    (ld_we),
        .inc      (inc)
    );

    pst_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_clr  (evt_clr),
        .ld_we    (ld_we),
        .ld_val   (ld_val),
        .inc      (inc),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

endmodule

// File: rtl/pst_timer16_chk.sv
// Module: pst_timer16_chk
// Port-level properties of the timer, bound to the top module.
module pst_timer16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             evt_clr,
    input logic             ld_we,
    input logic [CNT_W-1:0] ld_val,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag
);
    AST_EVT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> (count == '0)); // R9
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !evt_clr) |=> (count == $past(ld_val))); // R10
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !evt_clr && !ld_we) |=> $stable(count)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(count) == {CNT_W{1'b1}} && count == '0)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(evt_clr) && !$past(ld_we) && !$stable(count))
        |-> (count == $past(count) + 1'b1)); // R2
endmodule

bind pst_timer16 pst_timer16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .evt_clr  (evt_clr),
    .ld_we    (ld_we),
    .ld_val   (ld_val),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .ovf_flag (ovf_flag)
);

// File: tb/pst_timer16_tb.sv
`timescale 1ns/1ps
module pst_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        src_ext = 1'b0;
    logic [1:0]  pre_code = 2'd0;
    logic        sync_on = 1'b0;
    logic        ext_clk = 1'b0;
    logic        evt_clr = 1'b0;
    logic        ld_we = 1'b0;
    logic [15:0] ld_val = 16'd0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state
    int m_phase, m_pcnt, m_cnt;
    bit m_h1, m_h2, m_h3, m_ovf, m_src_prev;
    int m_pre_prev;

    always #2 clk = ~clk;

    pst_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
        .pre_code(pre_code), .sync_on(sync_on), .ext_clk(ext_clk),
        .evt_clr(evt_clr), .ld_we(ld_we), .ld_val(ld_val), .ovf_clr(ovf_clr),
        .count(count), .ovf_flag(ovf_flag)
    );

    task automatic check(input string t, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising edge, compared 1 ns later.
    always @(posedge clk) begin
        bit tick, ext_edge, restart, inc;
        int div;
        if (!rst_n) begin
            m_phase = 0; m_pcnt = 0; m_cnt = 0; m_ovf = 0;
            m_h1 = 0; m_h2 = 0; m_h3 = 0; m_src_prev = 0; m_pre_prev = 0;
        end else begin
            ext_edge = sync_on ? (m_h2 && !m_h3) : (m_h1 && !m_h2);
            tick     = src_ext ? ext_edge : (m_phase == 3);
            div      = 1 << pre_code;
            restart  = (int'(pre_code) != m_pre_prev) || (src_ext != m_src_prev) || ld_we;
            inc      = 0;
            if (restart) m_pcnt = 0;
            else if (run_en && tick) begin
                if (m_pcnt == div - 1) begin m_pcnt = 0; inc = 1; end
                else m_pcnt++;
            end
            if (evt_clr) m_cnt = 0;
            else if (ld_we) m_cnt = ld_val;
            else if (inc) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt++;
                if (m_cnt == 0) m_ovf = 1;
            end
            if (!(inc && !evt_clr && !ld_we && m_cnt == 0) && ovf_clr) m_ovf = 0;
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = ext_clk;
            m_phase = (m_phase + 1) % 4;
            m_pre_prev = pre_code; m_src_prev = src_ext;
        end
        #1;
        if (!done) begin
            check({tag, " count"}, count, m_cnt);
            check({tag, " ovf_flag"}, ovf_flag, m_ovf);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; cyc(hi);
            ext_clk = 1'b0; cyc(lo);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(4);
        check("R1 reset count", count, 0);
        check("R1 reset flag", ovf_flag, 0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 count after release", count, 0);

        tag = "R2"; run_en = 1'b1; cyc(40);
        tag = "R4"; pre_code = 2'd1; cyc(40);
        tag = "R11"; pre_code = 2'd2; cyc(3); pre_code = 2'd3; cyc(100);
        pre_code = 2'd2; cyc(50);

        tag = "R3"; src_ext = 1'b1; pre_code = 2'd0; sync_on = 1'b0;
        ext_pulses(10, 2, 2); ext_pulses(8, 1, 3); ext_pulses(6, 1, 1);
        tag = "R5"; sync_on = 1'b1;
        ext_pulses(10, 2, 2); ext_pulses(8, 1, 1);
        tag = "R4"; pre_code = 2'd2; ext_pulses(20, 1, 2);

        tag = "R6"; run_en = 1'b0;
        begin
            int held;
            held = count;
            ext_pulses(10, 1, 1);
            check("R6 held while off", count, held);
        end
        src_ext = 1'b0; cyc(12);

        tag = "R10"; ld_we = 1'b1; ld_val = 16'h1234; cyc(1);
        ld_we = 1'b0; check("R10 loaded", count, 16'h1234);
        run_en = 1'b1; pre_code = 2'd0;
        for (int i = 0; i < 8; i++) begin
            cyc(1 + i % 3); ld_we = 1'b1; ld_val = 16'h0A00 + 16'(i); cyc(1); ld_we = 1'b0;
        end

        tag = "R9"; evt_clr = 1'b1; ld_we = 1'b1; ld_val = 16'h5555; cyc(1);
        evt_clr = 1'b0; ld_we = 1'b0; check("R9 clear beats load", count, 0);
        cyc(10); evt_clr = 1'b1; cyc(1); evt_clr = 1'b0; cyc(10);

        tag = "R7"; ld_we = 1'b1; ld_val = 16'hFFFE; cyc(1); ld_we = 1'b0;
        cyc(12);
        check("R7 wrapped flag", ovf_flag, 1);
        tag = "R8"; cyc(20);
        check("R8 flag still set", ovf_flag, 1);
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
        check("R8 flag cleared", ovf_flag, 0);
        ld_we = 1'b1; ld_val = 16'hFFFF; cyc(1); ld_we = 1'b0;
        ovf_clr = 1'b1; cyc(12); ovf_clr = 1'b0; cyc(4);

        tag = "R9"; ld_we = 1'b1; ld_val = 16'hFFFF; cyc(1); ld_we = 1'b0;
        for (int i = 0; i < 6; i++) begin
            evt_clr = 1'b1; cyc(1); evt_clr = 1'b0;
            ld_we = 1'b1; cyc(1); ld_we = 1'b0; cyc(i);
        end
        cyc(10);
        finish_run();
    end
endmodule